// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the sending half of a clocked synchronous serial port. Software or an upstream engine hands it bytes through a single-entry holding register. The block moves each byte into a shift register and sends it least significant bit first on a serial data line. It either generates the serial clock itself from a divided system clock or follows a clock supplied from outside. Data changes on the falling edge of the serial clock, so the receiver samples on the rising edge. The serial clock idles high.

Writes use a valid/ready handshake. `wr_ready` is high exactly when the holding register is free, which is the same as the empty flag. A byte is taken on any cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the producer must hold `wr_valid` and `wr_data` until the byte is taken. When the MSB of a frame starts, the block looks at the holding register. If it holds a byte, including one taken in that same cycle, the next frame follows with no gap. If it is empty, the end flag is set and the last bit completes. After that, the data line keeps its level and the serial clock stays high. The two interrupt requests are levels, each gated by its own enable.

Top module: `sync_ser_tx`

## Requirements
- R1: During and after reset, empty_flag = 1, end_flag = 1, sdo = 1, sck_out = 1 and wr_ready = 1.
- R2: wr_ready equals empty_flag. An accepted write clears both empty_flag and end_flag on the next clock.
- R3: While no frame is active and the holding register is full, the byte is copied into the shift register and empty_flag returns to 1 on the next clock.
- R4: Each frame is 8 bits sent bit 0 first. sdo changes only on a falling edge of the serial clock and holds steady through the following rising edge.
- R5: In internal clock mode, each frame gives exactly 8 high-going serial clock pulses of 2×HALF_DIV system cycles each. sck_out stays high while no frame is active.
- R6: In external clock mode (ext_sel = 1), each synchronized falling edge of sck_in sends one bit during a frame, and edges are ignored when no frame is active. sck_out stays high in this mode.
- R7: If the holding register is full when bit 7 is sent, it is loaded at that moment, empty_flag is set, and the next frame's clock pulses continue at the same spacing.
- R8: If the holding register is empty when bit 7 is sent, end_flag is set, bit 7 is still sent, and afterwards sdo keeps bit 7's level and no further clock pulses are produced.
- R9: txi_irq is high exactly when txi_en and empty_flag are both high.
- R10: tei_irq is high exactly when tei_en and end_flag are both high.
- R11: A write accepted in the same clock cycle as the bit 7 check counts as a refill. The new byte follows with no gap, end_flag stays 0, and empty_flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A byte is offered to the holding register |
| wr_ready | output | 1 | Holding register is free; byte taken when wr_valid is also high |
| wr_data | input | 8 | Byte offered for transmission |
| ext_sel | input | 1 | 1 = follow sck_in, 0 = generate the serial clock internally |
| txi_en | input | 1 | Enable for the holding-register-empty request |
| tei_en | input | 1 | Enable for the transmit-end request |
| sck_in | input | 1 | External serial clock, asynchronous to clk |
| sck_out | output | 1 | Generated serial clock, idle high |
| sdo | output | 1 | Serial data, LSB first |
| empty_flag | output | 1 | Holding register has no unsent byte |
| end_flag | output | 1 | Transmission stopped after the last frame |
| txi_irq | output | 1 | Holding-register-empty interrupt request |
| tei_irq | output | 1 | Transmit-end interrupt request |

## Verification
A producer write and the bit 7 refill check can land in the same clock cycle. This is the case where the empty flag is both cleared and set, and where end is decided. The bench counts serial clock falls and places wr_valid so that it is taken on exactly the edge that sends bit 7. It then repeats the test with the write one cycle later. In the first case it expects two bytes with evenly spaced rising edges and end_flag staying low. In the second it expects end_flag to be seen high before the write and exactly one stretched interval between the two frames.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  typedef logic [FRAME_W-1:0] frame_t;

  function automatic int unsigned ctr_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sst_clk_unit.sv
module sst_clk_unit
  import sst_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic sck_in,
  output logic fall_p,
  output logic rise_p,
  output logic sck_out
);
  localparam int unsigned CW = ctr_width(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_q;
  logic          sck_q;
  logic          tick;

  // internal divider: runs only while a frame is active
  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (!run || ext_sel) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // external clock: two-flop synchronizer plus edge history
  logic [2:0] ext_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh <= 3'b111;
    else        ext_sh <= {ext_sh[1:0], sck_in};
  end

  logic ext_fall, ext_rise;
  assign ext_fall = ext_sh[2] & ~ext_sh[1];
  assign ext_rise = ~ext_sh[2] & ext_sh[1];

  always_comb begin
    if (ext_sel) begin
      fall_p = ext_fall;
      rise_p = ext_rise;
    end else begin
      fall_p = tick & sck_q;
      rise_p = tick & ~sck_q;
    end
  end

  assign sck_out = ext_sel ? 1'b1 : sck_q;
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t load_data,
  input  logic   fall_p,
  input  logic   rise_p,
  input  logic   refill_ok,
  input  frame_t refill_data,
  output logic   busy,
  output logic   sdo,
  output logic   msb_take,
  output logic   msb_stop
);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(FRAME_W - 1);

  frame_t           sh_q;
  logic [BIT_W-1:0] idx_q;
  logic             last_q;
  logic             msb_check;

  // the fall that drives the MSB is where the refill decision is made
  assign msb_check = busy && fall_p && (idx_q == MSB_IDX);
  assign msb_take  = msb_check && refill_ok;
  assign msb_stop  = msb_check && !refill_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
      busy   <= 1'b0;
      sdo    <= 1'b1;
    end else if (load) begin
      sh_q   <= load_data;
      idx_q  <= '0;
      last_q <= 1'b0;
      busy   <= 1'b1;
    end else if (busy) begin
      if (fall_p) begin
        sdo   <= sh_q[0];
        idx_q <= (idx_q == MSB_IDX) ? '0 : idx_q + 1'b1;
        if (msb_take)      sh_q <= refill_data;
        else               sh_q <= sh_q >> 1;
        if (msb_stop)      last_q <= 1'b1;
      end
      if (rise_p && last_q) begin
        busy   <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       ext_sel,
  input  logic       txi_en,
  input  logic       tei_en,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sdo,
  output logic       empty_flag,
  output logic       end_flag,
  output logic       txi_irq,
  output logic       tei_irq
);
  frame_t hold_q;
  logic   empty_q, end_q;
  logic   busy, fall_p, rise_p, msb_take, msb_stop;
  logic   wr_fire, load;
  frame_t refill_data;

  assign wr_ready = empty_q;
  assign wr_fire  = wr_valid && empty_q;
  assign load     = !busy && !empty_q;
  // a byte arriving in the check cycle is used directly
  assign refill_data = empty_q ? wr_data : hold_q;

  sst_clk_unit #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .ext_sel (ext_sel),
    .sck_in  (sck_in),
    .fall_p  (fall_p),
    .rise_p  (rise_p),
    .sck_out (sck_out)
  );

  sst_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .load_data   (hold_q),
    .fall_p      (fall_p),
    .rise_p      (rise_p),
    .refill_ok   (!empty_q || wr_fire),
    .refill_data (refill_data),
    .busy        (busy),
    .sdo         (sdo),
    .msb_take    (msb_take),
    .msb_stop    (msb_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      if (wr_fire) hold_q <= wr_data;
      if (load || msb_take) empty_q <= 1'b1;
      else if (wr_fire)     empty_q <= 1'b0;
      if (msb_stop)         end_q <= 1'b1;
      else if (wr_fire)     end_q <= 1'b0;
    end
  end

  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign txi_irq    = txi_en & empty_q;
  assign tei_irq    = tei_en & end_q;
endmodule

// File: rtl/sst_checker.sv
module sst_checker
  import sst_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic ext_sel,
  input logic wr_valid,
  input logic wr_ready,
  input logic sck_out,
  input logic sdo,
  input logic busy,
  input logic empty_flag,
  input logic end_flag
);
  logic             sck_d;
  logic [BIT_W-1:0] rise_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b1;
      rise_ctr <= '0;
    end else begin
      sck_d <= sck_out;
      if (!ext_sel && sck_out && !sck_d)
        rise_ctr <= (rise_ctr == BIT_W'(FRAME_W - 1)) ? '0 : rise_ctr + 1'b1;
    end
  end

  // R2: an accepted write leaves end cleared
  a_r2_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !end_flag);

  // R8: end is only raised when nothing was waiting
  a_r8_end_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(empty_flag));

  // R5: idle keeps clock high and data still
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> sck_out && $stable(sdo));

  // R4: data moves only with a falling serial clock
  a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel && !$stable(sdo) |-> $fell(sck_out));

  // R5: activity stops only after a whole number of frames
  a_r5_whole_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel && $fell(busy) |-> rise_ctr == BIT_W'(FRAME_W - 1));
endmodule

bind sync_ser_tx sst_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_sel    (ext_sel),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .sck_out    (sck_out),
  .sdo        (sdo),
  .busy       (busy),
  .empty_flag (empty_flag),
  .end_flag   (end_flag)
);

// File: tb/test_sync_ser_tx.sv
`timescale 1ns/1ps
module test_sync_ser_tx;
  localparam int HALF = 2;
  localparam int PER  = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       ext_sel = 1'b0;
  logic       txi_en = 1'b1;
  logic       tei_en = 1'b1;
  logic       sck_in = 1'b1;
  logic       sck_out, sdo, empty_flag, end_flag, txi_irq, tei_irq;

  always #2.5 clk = ~clk;

  sync_ser_tx #(.HALF_DIV(HALF)) i_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ext_sel(ext_sel), .txi_en(txi_en), .tei_en(tei_en),
    .sck_in(sck_in), .sck_out(sck_out), .sdo(sdo), .empty_flag(empty_flag),
    .end_flag(end_flag), .txi_irq(txi_irq), .tei_irq(tei_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // serial monitor, sampled at the falling system clock edge
  logic       mon_clr = 1'b0;
  logic [7:0] rx [0:299];
  int rx_n = 0, rise_n = 0, fall_n = 0, gap_n = 0, bitn = 0;
  int cyc = 0, last_rise = 0;
  bit have_rise = 0;
  logic sck_prev = 1'b1;
  logic [7:0] acc = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      rx_n = 0; rise_n = 0; fall_n = 0; gap_n = 0; bitn = 0; have_rise = 0;
    end else begin
      if (sck_out && !sck_prev) begin
        acc = {sdo, acc[7:1]};
        bitn++;
        if (bitn == 8) begin
          if (rx_n < 300) rx[rx_n] = acc;
          rx_n++;
          bitn = 0;
        end
        if (have_rise && (cyc - last_rise) != PER) gap_n++;
        last_rise = cyc;
        have_rise = 1;
        rise_n++;
      end
      if (!sck_out && sck_prev) fall_n++;
    end
    sck_prev = sck_out;
  end

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!end_flag) @(negedge clk);
    repeat (2 * PER) @(negedge clk);
  endtask

  task automatic wait_falls(input int n);
    @(posedge clk);
    while (fall_n != n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] held;
    logic [7:0] ext_acc;
    repeat (3) @(negedge clk);
    chk("R1 empty in reset", int'(empty_flag), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", int'(empty_flag), 1);
    chk("R1 end", int'(end_flag), 1);
    chk("R1 sdo", int'(sdo), 1);
    chk("R1 sck", int'(sck_out), 1);
    chk("R1 ready", int'(wr_ready), 1);
    chk("R9 txi at reset", int'(txi_irq), 1);
    chk("R10 tei at reset", int'(tei_irq), 1);

    // single frame 0x5A (bit 7 = 0)
    clear_mon();
    wr_valid = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2 empty cleared", int'(empty_flag), 0);
    chk("R2 end cleared", int'(end_flag), 0);
    chk("R2 ready follows empty", int'(wr_ready), 0);
    chk("R9 txi low", int'(txi_irq), 0);
    chk("R10 tei low", int'(tei_irq), 0);
    @(negedge clk);
    chk("R3 copied, empty set", int'(empty_flag), 1);
    chk("R9 txi high", int'(txi_irq), 1);
    wait_end();
    chk("R4 byte 5A", int'(rx[0]), 'h5A);
    chk("R4 one frame", rx_n, 1);
    chk("R5 eight pulses", rise_n, 8);
    chk("R5 pulse spacing", gap_n, 0);
    chk("R8 sdo keeps bit7", int'(sdo), 0);
    chk("R5 sck idle high", int'(sck_out), 1);
    chk("R10 tei on end", int'(tei_irq), 1);
    repeat (20) @(negedge clk);
    chk("R8 sdo held", int'(sdo), 0);
    chk("R8 no extra pulses", rise_n, 8);
    txi_en = 1'b0; tei_en = 1'b0;
    @(negedge clk);
    chk("R9 txi masked", int'(txi_irq), 0);
    chk("R10 tei masked", int'(tei_irq), 0);
    txi_en = 1'b1; tei_en = 1'b1;

    // exhaustive back-to-back sweep of all byte values
    clear_mon();
    for (int v = 0; v < 256; v++) write_byte(8'(v));
    wait_end();
    chk("R7 frame count", rx_n, 256);
    for (int v = 0; v < 256; v++) chk("R4 sweep byte", int'(rx[v]), v);
    chk("R7 no gaps", gap_n, 0);
    chk("R5 pulses in sweep", rise_n, 2048);
    chk("R8 end after sweep", int'(end_flag), 1);

    // write accepted on the very edge that sends bit 7
    clear_mon();
    write_byte(8'hC3);
    wait_falls(7);
    repeat (PER - 1) @(negedge clk);
    chk("R11 ready before check", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_data = 8'h96;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R11 end stays low", int'(end_flag), 0);
    chk("R11 empty set again", int'(empty_flag), 1);
    wait_end();
    chk("R11 first byte", int'(rx[0]), 'hC3);
    chk("R11 second byte", int'(rx[1]), 'h96);
    chk("R11 no gap", gap_n, 0);
    chk("R11 pulses", rise_n, 16);

    // write one cycle too late: stop, then restart after a gap
    clear_mon();
    write_byte(8'h0F);
    wait_falls(7);
    repeat (PER) @(negedge clk);
    chk("R8 end set at MSB", int'(end_flag), 1);
    wr_valid = 1'b1; wr_data = 8'hF0;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2 late write clears end", int'(end_flag), 0);
    @(negedge clk);
    while (rx_n < 2) @(negedge clk);
    wait_end();
    chk("R8 late first byte", int'(rx[0]), 'h0F);
    chk("R8 late second byte", int'(rx[1]), 'hF0);
    chk("R8 one gap", gap_n, 1);

    // external clock mode, byte 0xB4, two surplus pulses
    ext_sel = 1'b1;
    clear_mon();
    write_byte(8'hB4);
    repeat (4) @(negedge clk);
    ext_acc = '0;
    for (int p = 0; p < 10; p++) begin
      sck_in = 1'b0;
      repeat (5) @(negedge clk);
      if (p < 8) ext_acc = {sdo, ext_acc[7:1]};
      sck_in = 1'b1;
      repeat (5) @(negedge clk);
    end
    chk("R6 external byte", int'(ext_acc), 'hB4);
    chk("R6 surplus edges ignored", int'(sdo), 1);
    chk("R8 end in external mode", int'(end_flag), 1);
    chk("R6 sck_out constant", rise_n, 0);
    held = {7'd0, sdo};
    sck_in = 1'b0; repeat (5) @(negedge clk); sck_in = 1'b1; repeat (5) @(negedge clk);
    chk("R6 idle edge no effect", int'(sdo), int'(held));
    ext_sel = 1'b0;

    finish_run();
  end
endmodule